// File: doc/BRIEF.md
# Scatter-Gather Descriptor Sequencer

This block runs one DMA channel through a chain of transfers described by a table in memory. A primary stage does not move payload. It copies one four-word entry from the table into the channel's local alternate slot. The alternate slot then runs that entry's transfer, and control returns to the primary stage to fetch the next entry. The primary stage always moves whole words, one entry per pass. Its word counter starts at four times the number of entries minus one and counts down to zero. The first word it reads is at the table base, and its last pointer is the final word of the table.

The sequencer has two variants. In memory mode it starts as soon as the start pulse arrives. In peripheral mode it waits for the peripheral request line. While an entry is being copied, the sequencer rewrites that entry's control word in two ways. It clears the entry's own burst bit, because burst behaviour comes from the start-time setting. If the entry is the last one in the table, it forces the cycle code to a plain type, so that completion is always signalled. All memory traffic uses one word-wide port with a read latency of one cycle.

Top module: `sg_seq_top`

## Requirements
- R1: After reset, and whenever the block is idle, busy_o, done_o, mem_re_o and mem_we_o are low.
- R2: A table holds entries_m1_i+1 entries of four words each, starting at tbl_base_i. Within an entry, word +0 is the source end address, word +1 is the destination end address, word +2 is the control word and word +3 is not used. Entries run in ascending table order.
- R3: The control word has these fields: bits [2:0] are the cycle code, bit 3 is the entry burst bit, bit 4 is the source increment, bit 5 is the destination increment, and bits [15:6] are the element count minus one (n). Element i, counting from 0 to n, reads from (source end − (n − i)) when the source increments, and from the source end otherwise. The same rule applies to the write address on the destination side.
- R4: In memory mode (periph_mode_i = 0), table reads begin in the cycle after the start pulse, with no request needed.
- R5: Cycle codes: basic = 1, auto-request = 2, memory primary = 4, memory entry = 5, peripheral primary = 6, peripheral entry = 7. After an entry completes, the next entry is fetched only if that entry carries the entry code for the active mode (the mode's primary code plus one). Any other code ends the sequence, and later entries move no data.
- R6: The last table entry always ends the sequence and raises done, even if its code is the entry code. In memory mode its code becomes auto-request, and in peripheral mode it becomes basic.
- R7: done_o is high for exactly one cycle, in the cycle after the final data write. busy_o is low in that cycle.
- R8: In peripheral mode (periph_mode_i = 1), no memory access happens until periph_req_i is sampled high. Without burst, each data element then waits for its own sampled request.
- R9: If use_burst_i is set at start, one sampled request in peripheral mode moves all elements of an entry. The entry's own burst bit (bit 3) has no effect.
- R10: A start pulse that arrives while busy_o is high is ignored.
- R11: Any table length from 1 to 256 entries completes correctly.
- R12: Each data element is one read followed by a write in the next cycle, and the write carries the data that was read. Read and write are never asserted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | One-cycle start pulse, accepted only while idle |
| periph_mode_i | input | 1 | 0 selects memory mode, 1 selects peripheral mode |
| use_burst_i | input | 1 | Start-time burst setting that applies to all entries |
| tbl_base_i | input | AW | Word address of the first table word |
| entries_m1_i | input | ENT_W | Number of table entries minus one |
| periph_req_i | input | 1 | Peripheral request |
| mem_re_o | output | 1 | Memory read strobe |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | AW | Memory word address |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid one cycle after mem_re_o |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The properties assume that memory returns read data exactly one cycle after a read strobe. They also assume that the mode and burst inputs are stable around the start pulse, and that peripheral requests arrive as sampled levels. The bench's memory model registers its read data on the clock edge, and all inputs are driven on the falling edge. Requests are given only as single-cycle pulses, spaced far enough apart that each one lands while the sequencer is waiting for it. Every table the bench builds keeps its addresses inside the modelled memory and its element counts within the field width.

// File: rtl/sg_pkg.sv
package sg_pkg;
  localparam logic [2:0] CYC_BASIC   = 3'd1;
  localparam logic [2:0] CYC_AUTO    = 3'd2;
  localparam logic [2:0] CYC_MEM_SG  = 3'd4;
  localparam logic [2:0] CYC_MEM_ALT = CYC_MEM_SG + 3'd1;
  localparam logic [2:0] CYC_PER_SG  = 3'd6;
  localparam logic [2:0] CYC_PER_ALT = CYC_PER_SG + 3'd1;

  localparam int BURST_BIT = 3;
  localparam int SINC_BIT  = 4;
  localparam int DINC_BIT  = 5;
  localparam int CNT_LSB   = 6;

  typedef enum logic [2:0] {
    S_IDLE, S_ARM, S_CP_RD, S_CP_CAP, S_DT_WAIT, S_DT_RD, S_DT_WR, S_FIN
  } sg_state_e;

  typedef enum logic [1:0] {ASEL_COPY, ASEL_SRC, ASEL_DST} sg_asel_e;
endpackage

// File: rtl/sg_slot.sv
module sg_slot #(
  parameter int AW = 16,
  parameter int NW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic [1:0]    idx_i,
  input  logic [31:0]   data_i,
  input  logic          last_i,
  input  logic          periph_i,
  output logic [AW-1:0] src_end_o,
  output logic [AW-1:0] dst_end_o,
  output logic [2:0]    code_o,
  output logic          sinc_o,
  output logic          dinc_o,
  output logic [NW-1:0] n_o
);
  import sg_pkg::*;

  logic [AW-1:0] src_q, src_d, dst_q, dst_d;
  logic [2:0]    code_q, code_d;
  logic          sinc_q, sinc_d, dinc_q, dinc_d;
  logic [NW-1:0] n_q, n_d;
  logic          unused_bits;

  // word +3 and the entry burst bit are dropped on purpose
  assign unused_bits = ^{data_i[31:CNT_LSB+NW], data_i[BURST_BIT], data_i[31:AW]};

  always_comb begin
    src_d  = src_q;
    dst_d  = dst_q;
    code_d = code_q;
    sinc_d = sinc_q;
    dinc_d = dinc_q;
    n_d    = n_q;
    if (wr_en_i) begin
      case (idx_i)
        2'd0: src_d = data_i[AW-1:0];
        2'd1: dst_d = data_i[AW-1:0];
        2'd2: begin
          code_d = last_i ? (periph_i ? CYC_BASIC : CYC_AUTO) : data_i[2:0];
          sinc_d = data_i[SINC_BIT];
          dinc_d = data_i[DINC_BIT];
          n_d    = data_i[CNT_LSB +: NW];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      dst_q  <= '0;
      code_q <= '0;
      sinc_q <= 1'b0;
      dinc_q <= 1'b0;
      n_q    <= '0;
    end else if (wr_en_i) begin
      src_q  <= src_d;
      dst_q  <= dst_d;
      code_q <= code_d;
      sinc_q <= sinc_d;
      dinc_q <= dinc_d;
      n_q    <= n_d;
    end
  end

  assign src_end_o = src_q;
  assign dst_end_o = dst_q;
  assign code_o    = code_q;
  assign sinc_o    = sinc_q;
  assign dinc_o    = dinc_q;
  assign n_o       = n_q;
endmodule

// File: rtl/sg_elem_addr.sv
module sg_elem_addr #(
  parameter int AW = 16,
  parameter int NW = 10
) (
  input  logic [AW-1:0] src_end_i,
  input  logic [AW-1:0] dst_end_i,
  input  logic          sinc_i,
  input  logic          dinc_i,
  input  logic [NW-1:0] d_rem_i,
  output logic [AW-1:0] src_addr_o,
  output logic [AW-1:0] dst_addr_o
);
  logic [AW-1:0] rem_ext;

  assign rem_ext    = AW'(d_rem_i);
  assign src_addr_o = sinc_i ? (src_end_i - rem_ext) : src_end_i;
  assign dst_addr_o = dinc_i ? (dst_end_i - rem_ext) : dst_end_i;
endmodule

// File: rtl/sg_ctrl.sv
module sg_ctrl #(
  parameter int AW    = 16,
  parameter int ENT_W = 8,
  parameter int NW    = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             periph_mode_i,
  input  logic             use_burst_i,
  input  logic [AW-1:0]    tbl_base_i,
  input  logic [ENT_W-1:0] entries_m1_i,
  input  logic             periph_req_i,
  input  logic [2:0]       slot_code_i,
  input  logic [NW-1:0]    slot_n_i,
  output logic             slot_wr_o,
  output logic [1:0]       slot_idx_o,
  output logic             slot_last_o,
  output logic             periph_q_o,
  output logic             mem_re_o,
  output logic             mem_we_o,
  output sg_pkg::sg_asel_e asel_o,
  output logic [AW-1:0]    copy_addr_o,
  output logic [NW-1:0]    d_rem_o,
  output logic             busy_o,
  output logic             done_o
);
  import sg_pkg::*;

  localparam int PW = ENT_W + 2;

  sg_state_e     st_q, st_d;
  logic          per_q, per_d, bst_q, bst_d, exh_q, exh_d;
  logic [AW-1:0] tend_q, tend_d;
  logic [PW-1:0] prem_q, prem_d, prem_init;
  logic [NW-1:0] drem_q, drem_d;
  logic [2:0]    alt_code;

  assign prem_init = {entries_m1_i, 2'b11};
  assign alt_code  = per_q ? CYC_PER_ALT : CYC_MEM_ALT;

  always_comb begin
    st_d   = st_q;
    per_d  = per_q;
    bst_d  = bst_q;
    exh_d  = exh_q;
    tend_d = tend_q;
    prem_d = prem_q;
    drem_d = drem_q;
    case (st_q)
      S_IDLE: if (start_i) begin
        per_d  = periph_mode_i;
        bst_d  = use_burst_i;
        exh_d  = 1'b0;
        tend_d = tbl_base_i + AW'(prem_init);
        prem_d = prem_init;
        st_d   = periph_mode_i ? S_ARM : S_CP_RD;
      end
      S_ARM:    if (periph_req_i) st_d = S_CP_RD;
      S_CP_RD:  st_d = S_CP_CAP;
      S_CP_CAP: begin
        if (prem_q != '0) prem_d = prem_q - 1'b1;
        if (prem_q[1:0] == 2'b00) begin
          drem_d = slot_n_i;
          exh_d  = (prem_q == '0);
          st_d   = per_q ? S_DT_WAIT : S_DT_RD;
        end else begin
          st_d = S_CP_RD;
        end
      end
      S_DT_WAIT: if (periph_req_i) st_d = S_DT_RD;
      S_DT_RD:   st_d = S_DT_WR;
      S_DT_WR: begin
        if (drem_q == '0) begin
          st_d = ((slot_code_i == alt_code) && !exh_q) ? S_CP_RD : S_FIN;
        end else begin
          drem_d = drem_q - 1'b1;
          st_d   = (per_q && !bst_q) ? S_DT_WAIT : S_DT_RD;
        end
      end
      S_FIN:   st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      per_q  <= 1'b0;
      bst_q  <= 1'b0;
      exh_q  <= 1'b0;
      tend_q <= '0;
      prem_q <= '0;
      drem_q <= '0;
    end else begin
      st_q   <= st_d;
      per_q  <= per_d;
      bst_q  <= bst_d;
      exh_q  <= exh_d;
      tend_q <= tend_d;
      prem_q <= prem_d;
      drem_q <= drem_d;
    end
  end

  always_comb begin
    case (st_q)
      S_DT_RD: asel_o = ASEL_SRC;
      S_DT_WR: asel_o = ASEL_DST;
      default: asel_o = ASEL_COPY;
    endcase
  end

  assign mem_re_o    = (st_q == S_CP_RD) || (st_q == S_DT_RD);
  assign mem_we_o    = (st_q == S_DT_WR);
  assign slot_wr_o   = (st_q == S_CP_CAP);
  assign slot_idx_o  = ~prem_q[1:0];
  assign slot_last_o = (prem_q[PW-1:2] == '0);
  assign periph_q_o  = per_q;
  assign copy_addr_o = tend_q - AW'(prem_q);
  assign d_rem_o     = drem_q;
  assign busy_o      = (st_q != S_IDLE) && (st_q != S_FIN);
  assign done_o      = (st_q == S_FIN);
endmodule

// File: rtl/sg_seq_top.sv
module sg_seq_top #(
  parameter int AW    = 16,
  parameter int ENT_W = 8,
  parameter int NW    = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             periph_mode_i,
  input  logic             use_burst_i,
  input  logic [AW-1:0]    tbl_base_i,
  input  logic [ENT_W-1:0] entries_m1_i,
  input  logic             periph_req_i,
  output logic             mem_re_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [31:0]      mem_wdata_o,
  input  logic [31:0]      mem_rdata_i,
  output logic             busy_o,
  output logic             done_o
);
  import sg_pkg::*;

  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  logic          slot_wr, slot_last, per_q, sinc, dinc;
  logic [1:0]    slot_idx;
  logic [AW-1:0] src_end, dst_end, copy_addr, src_addr, dst_addr;
  logic [2:0]    slot_code;
  logic [NW-1:0] slot_n, d_rem;
  sg_asel_e      asel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  sg_ctrl #(.AW(AW), .ENT_W(ENT_W), .NW(NW)) ctrl_i (
    .clk(clk), .rst_n(rst_int_n), .start_i(start_i),
    .periph_mode_i(periph_mode_i), .use_burst_i(use_burst_i),
    .tbl_base_i(tbl_base_i), .entries_m1_i(entries_m1_i),
    .periph_req_i(periph_req_i), .slot_code_i(slot_code), .slot_n_i(slot_n),
    .slot_wr_o(slot_wr), .slot_idx_o(slot_idx), .slot_last_o(slot_last),
    .periph_q_o(per_q), .mem_re_o(mem_re_o), .mem_we_o(mem_we_o),
    .asel_o(asel), .copy_addr_o(copy_addr), .d_rem_o(d_rem),
    .busy_o(busy_o), .done_o(done_o)
  );

  sg_slot #(.AW(AW), .NW(NW)) slot_i (
    .clk(clk), .rst_n(rst_int_n), .wr_en_i(slot_wr), .idx_i(slot_idx),
    .data_i(mem_rdata_i), .last_i(slot_last), .periph_i(per_q),
    .src_end_o(src_end), .dst_end_o(dst_end), .code_o(slot_code),
    .sinc_o(sinc), .dinc_o(dinc), .n_o(slot_n)
  );

  sg_elem_addr #(.AW(AW), .NW(NW)) addr_i (
    .src_end_i(src_end), .dst_end_i(dst_end), .sinc_i(sinc), .dinc_i(dinc),
    .d_rem_i(d_rem), .src_addr_o(src_addr), .dst_addr_o(dst_addr)
  );

  always_comb begin
    case (asel)
      ASEL_SRC: mem_addr_o = src_addr;
      ASEL_DST: mem_addr_o = dst_addr;
      default:  mem_addr_o = copy_addr;
    endcase
  end

  assign mem_wdata_o = mem_we_o ? mem_rdata_i : 32'd0;
endmodule

// File: rtl/sg_seq_chk.sv
module sg_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic periph_mode_i,
  input logic mem_re_o,
  input logic mem_we_o,
  input logic busy_o,
  input logic done_o
);
  a_r12_no_rw_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re_o && mem_we_o));

  a_r12_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> $past(mem_re_o));

  a_r7_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r7_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!mem_re_o && !mem_we_o));

  a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> (busy_o || done_o));

  a_r8_arm_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !$past(busy_o) && $past(periph_mode_i)) |-> !mem_re_o);

  a_r4_mem_starts_at_once: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !$past(busy_o) && !$past(periph_mode_i)) |-> mem_re_o);
endmodule

bind sg_seq_top sg_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .periph_mode_i(periph_mode_i),
  .mem_re_o(mem_re_o), .mem_we_o(mem_we_o), .busy_o(busy_o), .done_o(done_o)
);

// File: tb/sg_seq_top_tb_top.sv
module sg_seq_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, per_mode, use_burst, preq;
  logic [15:0] tbl_base;
  logic [7:0]  em1;
  logic        mem_re, mem_we, busy, done;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata, rdata;
  logic [31:0] mem [0:2047];

  int total = 0, bad = 0, cyc = 0;
  int wr_cnt = 0, re_cnt = 0, done_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sg_seq_top dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .periph_mode_i(per_mode),
    .use_burst_i(use_burst), .tbl_base_i(tbl_base), .entries_m1_i(em1),
    .periph_req_i(preq), .mem_re_o(mem_re), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(rdata),
    .busy_o(busy), .done_o(done)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[10:0]] <= mem_wdata;
    if (mem_re) rdata <= mem[mem_addr[10:0]];
    if (mem_we) wr_cnt <= wr_cnt + 1;
    if (mem_re) re_cnt <= re_cnt + 1;
    if (done) done_cnt <= done_cnt + 1;
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      total++; bad++;
      $display("FAIL watchdog (all requirements) act=%0d exp=<150000 cycles", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_ctrl(logic [2:0] code, bit bst, bit si, bit di, int n);
    return (32'(n) << 6) | (32'(di) << 5) | (32'(si) << 4) | (32'(bst) << 3) | 32'(code);
  endfunction

  task automatic put_entry(int base, int idx, int se, int de, logic [31:0] c);
    mem[base + 4*idx]     = 32'(se);
    mem[base + 4*idx + 1] = 32'(de);
    mem[base + 4*idx + 2] = c;
    mem[base + 4*idx + 3] = 32'hDEAD_0000 + 32'(idx);
  endtask

  task automatic clear_dst();
    for (int i = 12'h600; i < 12'h800; i++) mem[i] = 32'd0;
  endtask

  task automatic kick(bit p, bit b, int base, int e);
    @(negedge clk);
    per_mode = p; use_burst = b; tbl_base = 16'(base); em1 = 8'(e); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(int d0, int lim, output bit seen);
    seen = 1'b0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (done_cnt != d0) begin seen = 1'b1; break; end
    end
  endtask

  task automatic pulse_req();
    @(negedge clk); preq = 1'b1;
    @(negedge clk); preq = 1'b0;
    repeat (20) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!busy && !done && !mem_re && !mem_we, "R1 reset outputs idle",
        {28'd0, busy, done, mem_re, mem_we}, 32'd0);
  endtask

  task automatic t_single();
    bit seen;
    int d0;
    clear_dst();
    for (int i = 0; i < 4; i++) mem[12'h400 + i] = 32'hA000_0000 + 32'(i);
    put_entry(0, 0, 12'h403, 12'h603, mk_ctrl(3'd5, 0, 1, 1, 3));
    d0 = done_cnt;
    kick(0, 0, 0, 0);
    seen = 1'b0;
    for (int i = 0; i < 200; i++) begin
      if (done) begin seen = 1'b1; break; end
      @(negedge clk);
    end
    chk(seen, "R6 last entry with entry code still raises done", 32'(seen), 32'd1);
    chk(!busy, "R7 busy low with done", 32'(busy), 32'd0);
    @(negedge clk);
    chk(!done && !busy, "R7 done lasts one cycle", {30'd0, done, busy}, 32'd0);
    for (int i = 0; i < 4; i++)
      chk(mem[12'h600 + i] == 32'hA000_0000 + 32'(i), "R2 R3 R4 single entry copy",
          mem[12'h600 + i], 32'hA000_0000 + 32'(i));
    chk(done_cnt == d0 + 1, "R7 exactly one done pulse", 32'(done_cnt - d0), 32'd1);
  endtask

  task automatic t_multi();
    bit seen;
    int d0, w0;
    clear_dst();
    for (int i = 0; i < 4; i++) mem[12'h410 + i] = 32'hB100_0000 + 32'(i);
    mem[12'h420] = 32'hB200_0055;
    for (int i = 0; i < 3; i++) mem[12'h430 + i] = 32'hB300_0000 + 32'(i);
    put_entry(12'h40, 0, 12'h413, 12'h613, mk_ctrl(3'd5, 0, 1, 1, 3));
    put_entry(12'h40, 1, 12'h420, 12'h622, mk_ctrl(3'd5, 0, 0, 1, 2));
    put_entry(12'h40, 2, 12'h432, 12'h630, mk_ctrl(3'd5, 0, 1, 0, 2));
    d0 = done_cnt; w0 = wr_cnt;
    kick(0, 0, 12'h40, 2);
    repeat (5) @(negedge clk);
    tbl_base = 16'h100; em1 = 8'd0; start = 1'b1;  // R10: restart while busy
    @(negedge clk); start = 1'b0;
    wait_done(d0, 2000, seen);
    chk(seen, "R5 three entry chain completes", 32'(seen), 32'd1);
    for (int i = 0; i < 4; i++)
      chk(mem[12'h610 + i] == 32'hB100_0000 + 32'(i), "R3 both sides increment",
          mem[12'h610 + i], 32'hB100_0000 + 32'(i));
    for (int i = 0; i < 3; i++)
      chk(mem[12'h620 + i] == 32'hB200_0055, "R3 fixed source fills",
          mem[12'h620 + i], 32'hB200_0055);
    chk(mem[12'h630] == 32'hB300_0002, "R3 fixed destination keeps last element",
        mem[12'h630], 32'hB300_0002);
    chk(mem[12'h631] == 32'd0, "R3 fixed destination no spill", mem[12'h631], 32'd0);
    chk(wr_cnt - w0 == 10, "R10 R12 one write per element, restart ignored",
        32'(wr_cnt - w0), 32'd10);
  endtask

  task automatic t_early_end();
    bit seen;
    int d0, w0;
    clear_dst();
    mem[12'h440] = 32'hC000_0001;
    mem[12'h441] = 32'hC000_0002;
    put_entry(12'h80, 0, 12'h440, 12'h640, mk_ctrl(3'd1, 0, 1, 1, 0));
    put_entry(12'h80, 1, 12'h441, 12'h641, mk_ctrl(3'd5, 0, 1, 1, 0));
    d0 = done_cnt; w0 = wr_cnt;
    kick(0, 0, 12'h80, 1);
    wait_done(d0, 500, seen);
    chk(seen, "R5 plain code ends sequence with done", 32'(seen), 32'd1);
    chk(mem[12'h640] == 32'hC000_0001, "R5 first entry moved", mem[12'h640], 32'hC000_0001);
    chk(mem[12'h641] == 32'd0, "R5 later entry untouched", mem[12'h641], 32'd0);
    chk(wr_cnt - w0 == 1, "R5 only one write", 32'(wr_cnt - w0), 32'd1);
  endtask

  task automatic t_periph();
    int d0, w0, r0;
    clear_dst();
    mem[12'h450] = 32'hD000_0000;
    mem[12'h451] = 32'hD000_0001;
    mem[12'h452] = 32'hD000_0002;
    put_entry(12'hC0, 0, 12'h451, 12'h651, mk_ctrl(3'd7, 1, 1, 1, 1));
    put_entry(12'hC0, 1, 12'h452, 12'h652, mk_ctrl(3'd7, 0, 1, 1, 0));
    d0 = done_cnt; w0 = wr_cnt; r0 = re_cnt;
    kick(1, 0, 12'hC0, 1);
    repeat (20) @(negedge clk);
    chk(re_cnt == r0 && busy, "R8 no access before request", 32'(re_cnt - r0), 32'd0);
    pulse_req();
    chk(wr_cnt == w0, "R8 first request only arms the copy", 32'(wr_cnt - w0), 32'd0);
    pulse_req();
    chk(wr_cnt - w0 == 1, "R9 entry burst bit ignored, one element per request",
        32'(wr_cnt - w0), 32'd1);
    pulse_req();
    chk(wr_cnt - w0 == 2, "R8 second element on next request", 32'(wr_cnt - w0), 32'd2);
    chk(done_cnt == d0, "R8 not done before last entry", 32'(done_cnt - d0), 32'd0);
    pulse_req();
    chk(done_cnt == d0 + 1, "R6 peripheral last entry done", 32'(done_cnt - d0), 32'd1);
    chk(mem[12'h650] == 32'hD000_0000 && mem[12'h651] == 32'hD000_0001 &&
        mem[12'h652] == 32'hD000_0002, "R2 peripheral data", mem[12'h652], 32'hD000_0002);
  endtask

  task automatic t_burst();
    int d0, w0;
    clear_dst();
    for (int i = 0; i < 4; i++) mem[12'h460 + i] = 32'hE000_0000 + 32'(i);
    put_entry(12'h100, 0, 12'h463, 12'h663, mk_ctrl(3'd7, 0, 1, 1, 3));
    d0 = done_cnt; w0 = wr_cnt;
    kick(1, 1, 12'h100, 0);
    pulse_req();
    chk(wr_cnt == w0, "R9 arm request moves no data", 32'(wr_cnt - w0), 32'd0);
    pulse_req();
    chk(wr_cnt - w0 == 4, "R9 one request moves whole entry", 32'(wr_cnt - w0), 32'd4);
    chk(done_cnt == d0 + 1, "R9 burst entry done", 32'(done_cnt - d0), 32'd1);
    chk(mem[12'h663] == 32'hE000_0003, "R9 burst data", mem[12'h663], 32'hE000_0003);
  endtask

  task automatic t_max();
    bit seen;
    int d0, w0, nbad;
    clear_dst();
    for (int i = 0; i < 256; i++) begin
      mem[12'h400 + i] = 32'h5A00_0000 + 32'(i);
      put_entry(0, i, 12'h400 + i, 12'h600 + i, mk_ctrl(3'd5, 0, 1, 1, 0));
    end
    d0 = done_cnt; w0 = wr_cnt;
    kick(0, 0, 0, 255);
    wait_done(d0, 20000, seen);
    chk(seen, "R11 256 entries complete", 32'(seen), 32'd1);
    nbad = 0;
    for (int i = 0; i < 256; i++)
      if (mem[12'h600 + i] != 32'h5A00_0000 + 32'(i)) nbad++;
    chk(nbad == 0, "R11 all 256 entries moved", 32'(nbad), 32'd0);
    chk(wr_cnt - w0 == 256, "R11 write count", 32'(wr_cnt - w0), 32'd256);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; per_mode = 1'b0; use_burst = 1'b0; preq = 1'b0;
    tbl_base = '0; em1 = '0;
    for (int i = 0; i < 2048; i++) mem[i] = 32'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_single();
    t_multi();
    t_early_end();
    t_periph();
    t_burst();
    t_max();
    repeat (5) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule